// File: doc/BRIEF.md
# LED Blink and Ramp Effect Sequencer

This block sets the lighting effect of a bank of LED current-source channels. Every channel has a register holding a current code and a two-bit effect mode. A channel can show its code steadily, flash it on and off, or move it along a slow brightness ramp. One effects register sets the values that all channels share: the flash on-time, the flash period, the ramp duration and the ramp direction. A command register holds a software shutdown bit. All registers are written through a parallel write port, and all timing counts a 1 kHz clock-enable tick.

The block drives one effective current code per channel. It also drives a charge-pump boost request and a shutdown flag. Flash timing and ramp timing come from two separate counters, so changing the rate of one never resets the other. A single ramp level is shared by all channels. A ramping channel shows the smaller of that level and its own code. The boost request has hysteresis: it is set when any output reaches a threshold, and it goes back to the 1x setting when a down-ramp ends.

Top module: `ledfx_seq`

## Requirements
- R1: While `rstN` is low: `shutdown` is 1, every output code is 0, `cpBoost` is 0, and writes are ignored. After release, every register is zero, so `shutdown` stays 1.
- R2: A channel register holds the code in bits [5:0] and the mode in bits [7:6]. In mode 00 (static) the channel outputs its code continuously, from the cycle after the write.
- R3: In mode 01 (flash) the channel outputs its code while the flash counter is below the on-time, and 0 otherwise. The flash counter advances once per tick and wraps at the period. The effects register (address 19) selects the on-time with bit 0 (0: 156 ticks, 1: 625 ticks) and the period with bit 1 (0: 1250 ticks, 1: 2500 ticks).
- R4: Writing new flash or ramp-duration settings neither restarts nor disturbs the other counter.
- R5: Effects bit 4 set to 1 selects an up-ramp. The shared level starts at 0 and rises one LSB per step to 63. In mode 10 a channel outputs min(level, code).
- R6: Effects bit 4 set to 0 selects a down-ramp. The level starts at 63 and falls one LSB per step to 0.
- R7: One ramp step takes round(duration/63) ticks. Effects bits [3:2] select the duration: 00 gives 240 ticks (4 per step), 01 gives 480 ticks (8 per step), and 10 or 11 gives 960 ticks (15 per step).
- R8: A ramp restarts only when a write changes the direction bit or changes a channel's mode field. A finished ramp holds its end level.
- R9: `shutdown` is 1, and every output is 0, when every channel code is 0 or when bit 0 of the command register (address 0) is 1.
- R10: `cpBoost` becomes 1 at the edge after any output code is 32 or more, and it then holds. It clears at the edge where a down-ramp takes its final step, and it stays clear during shutdown.
- R11: The flash counter and the ramp step counter advance only on cycles where `tick` is 1.
- R12: Mode 11 behaves the same as static. Writes to addresses 20 to 31 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; clears all state |
| tick | input | 1 | 1 kHz clock-enable for all effect timing |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register address: 0 command, 1..18 channels, 19 effects |
| wrData | input | 8 | Register write data |
| ledCode | output | 108 | Effective 6-bit code per channel; channel n in bits [6n+5:6n], n counted from 0 |
| cpBoost | output | 1 | Charge-pump boost request (0 means 1x) |
| shutdown | output | 1 | Block is in shutdown |

## Verification
A wrong flash-counter state shows at the ports as an on/off edge in the wrong cycle on any flashing channel, within one period. A wrong ramp level or step count shows on a ramping channel as a code change that comes a cycle early or late, or that skips a value. A wrong boost hysteresis shows as `cpBoost` dropping while a ramp is still running, or staying set after a down-ramp ends. The bench keeps a cycle model and compares every output on every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/ledfx_pkg.sv
package ledfx_pkg;

  // Channel effect modes, held in the two top bits of a channel register.
  typedef enum logic [1:0] {
    MODE_STATIC = 2'b00,
    MODE_FLASH  = 2'b01,
    MODE_RAMP   = 2'b10,
    MODE_ALT    = 2'b11
  } fxMode_e;

  // Strobes the control module sends to the datapath.
  typedef struct packed {
    logic flashOn;
    logic downDone;
    logic shutdown;
  } fxStrobe_t;

endpackage

// File: rtl/ledfx_ctrl.sv
module ledfx_ctrl
  import ledfx_pkg::*;
#(
  parameter int NUM_CH    = 18,
  parameter int CODE_W    = 6,
  parameter int ON_SHORT  = 156,
  parameter int ON_LONG   = 625,
  parameter int PER_SHORT = 1250,
  parameter int PER_LONG  = 2500,
  parameter int RAMP_T0   = 240,
  parameter int RAMP_T1   = 480,
  parameter int RAMP_T2   = 960,
  localparam int DATA_W   = CODE_W + 2,
  localparam int ADDR_W   = $clog2(NUM_CH + 2)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           tick,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [DATA_W-1:0]              wrData,
  output logic [NUM_CH-1:0][CODE_W-1:0]  chCode,
  output logic [NUM_CH-1:0][1:0]         chMode,
  output logic [CODE_W-1:0]              rampLevel,
  output fxStrobe_t                      strobes
);

  localparam int MAXC     = (1 << CODE_W) - 1;
  localparam int STEP0    = (RAMP_T0 + MAXC / 2) / MAXC;
  localparam int STEP1    = (RAMP_T1 + MAXC / 2) / MAXC;
  localparam int STEP2    = (RAMP_T2 + MAXC / 2) / MAXC;
  localparam int SW       = $clog2(STEP2 + 1);
  localparam int BW       = $clog2(PER_LONG + 1);
  localparam int FX_ADDR  = NUM_CH + 1;
  localparam int B_ONSEL  = 0;
  localparam int B_PERSEL = 1;
  localparam int B_RAMPLO = 2;
  localparam int B_DIR    = 4;

  // Register state
  logic                onSelQ, perSelQ, dirQ, shutBitQ;
  logic [1:0]          rampSelQ;

  // Timebase and ramp state
  logic [BW-1:0]       flashCnt;
  logic [SW-1:0]       stepCnt;
  logic                rampActive;
  logic                modeChange, dirChange, restart, newDir;
  logic                stepNow, downDone, allZero;
  logic [BW-1:0]       perTicks, onTicks;
  logic [SW-1:0]       stepTicks;

  // Register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chCode   <= '0;
      chMode   <= '0;
      onSelQ   <= 1'b0;
      perSelQ  <= 1'b0;
      rampSelQ <= 2'b00;
      dirQ     <= 1'b0;
      shutBitQ <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == '0) begin
        shutBitQ <= wrData[0];
      end else if (wrAddr == ADDR_W'(FX_ADDR)) begin
        onSelQ   <= wrData[B_ONSEL];
        perSelQ  <= wrData[B_PERSEL];
        rampSelQ <= wrData[B_RAMPLO +: 2];
        dirQ     <= wrData[B_DIR];
      end else begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (wrAddr == ADDR_W'(c + 1)) begin
            chCode[c] <= wrData[CODE_W-1:0];
            chMode[c] <= wrData[DATA_W-1 -: 2];
          end
        end
      end
    end
  end

  // Ramp restart detection
  always_comb begin
    modeChange = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (wrEn && wrAddr == ADDR_W'(c + 1) && wrData[DATA_W-1 -: 2] != chMode[c])
        modeChange = 1'b1;
    end
  end

  assign dirChange = wrEn && (wrAddr == ADDR_W'(FX_ADDR)) && (wrData[B_DIR] != dirQ);
  assign restart   = modeChange || dirChange;
  assign newDir    = dirChange ? wrData[B_DIR] : dirQ;

  // Rate selection
  assign perTicks = perSelQ ? BW'(PER_LONG) : BW'(PER_SHORT);
  assign onTicks  = onSelQ  ? BW'(ON_LONG)  : BW'(ON_SHORT);

  always_comb begin
    case (rampSelQ)
      2'b00:   stepTicks = SW'(STEP0);
      2'b01:   stepTicks = SW'(STEP1);
      default: stepTicks = SW'(STEP2);
    endcase
  end

  // Flash timebase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashCnt <= '0;
    end else if (tick) begin
      if (flashCnt >= perTicks - BW'(1)) flashCnt <= '0;
      else                               flashCnt <= flashCnt + BW'(1);
    end
  end

  // Ramp engine
  assign stepNow  = rampActive && tick && (stepCnt >= stepTicks - SW'(1)) && !restart;
  assign downDone = stepNow && !dirQ && (rampLevel == CODE_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampLevel  <= '0;
      stepCnt    <= '0;
      rampActive <= 1'b0;
    end else if (restart) begin
      rampLevel  <= newDir ? '0 : CODE_W'(MAXC);
      stepCnt    <= '0;
      rampActive <= 1'b1;
    end else if (rampActive && tick) begin
      if (stepNow) begin
        stepCnt <= '0;
        if (dirQ) begin
          rampLevel <= rampLevel + CODE_W'(1);
          if (rampLevel == CODE_W'(MAXC - 1)) rampActive <= 1'b0;
        end else begin
          rampLevel <= rampLevel - CODE_W'(1);
          if (rampLevel == CODE_W'(1)) rampActive <= 1'b0;
        end
      end else begin
        stepCnt <= stepCnt + SW'(1);
      end
    end
  end

  // Shutdown decode
  always_comb begin
    allZero = 1'b1;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chCode[c] != '0) allZero = 1'b0;
    end
  end

  assign strobes.flashOn  = (flashCnt < onTicks);
  assign strobes.downDone = downDone;
  assign strobes.shutdown = !rstN || shutBitQ || allZero;

  // Assertions
  a_r11_flash_hold_no_tick : assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(flashCnt));

  a_r11_step_hold_no_tick : assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !restart) |=> $stable(stepCnt));

  a_r5_one_lsb_per_step : assert property (@(posedge clk) disable iff (!rstN)
    !restart |=> (rampLevel == $past(rampLevel) ||
                  rampLevel == $past(rampLevel) + CODE_W'(1) ||
                  rampLevel == $past(rampLevel) - CODE_W'(1)));

  a_r6_down_ends_at_zero : assert property (@(posedge clk) disable iff (!rstN)
    downDone |=> (rampLevel == '0 && !rampActive));

endmodule

// File: rtl/ledfx_datapath.sv
module ledfx_datapath
  import ledfx_pkg::*;
#(
  parameter int NUM_CH     = 18,
  parameter int CODE_W     = 6,
  parameter int BOOST_CODE = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0][CODE_W-1:0] chCode,
  input  logic [NUM_CH-1:0][1:0]        chMode,
  input  logic [CODE_W-1:0]             rampLevel,
  input  fxStrobe_t                     strobes,
  output logic [NUM_CH*CODE_W-1:0]      ledCode,
  output logic                          cpBoost
);

  logic [NUM_CH-1:0] highVec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CODE_W-1:0] chOut;
    always_comb begin
      if (strobes.shutdown) begin
        chOut = '0;
      end else begin
        case (fxMode_e'(chMode[c]))
          MODE_FLASH: chOut = strobes.flashOn ? chCode[c] : '0;
          MODE_RAMP:  chOut = (rampLevel < chCode[c]) ? rampLevel : chCode[c];
          default:    chOut = chCode[c];
        endcase
      end
    end
    assign ledCode[c*CODE_W +: CODE_W] = chOut;
    assign highVec[c] = (chOut >= CODE_W'(BOOST_CODE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      cpBoost <= 1'b0;
    else if (strobes.shutdown || strobes.downDone) cpBoost <= 1'b0;
    else if (|highVec)                             cpBoost <= 1'b1;
  end

  a_r9_dark_in_shutdown : assert property (@(posedge clk) disable iff (!rstN)
    strobes.shutdown |-> (ledCode == '0));

  a_r10_boost_released : assert property (@(posedge clk) disable iff (!rstN)
    strobes.downDone |=> !cpBoost);

endmodule

// File: rtl/ledfx_seq.sv
module ledfx_seq
  import ledfx_pkg::*;
#(
  parameter int NUM_CH     = 18,
  parameter int CODE_W     = 6,
  parameter int BOOST_CODE = 32,
  parameter int ON_SHORT   = 156,
  parameter int ON_LONG    = 625,
  parameter int PER_SHORT  = 1250,
  parameter int PER_LONG   = 2500,
  parameter int RAMP_T0    = 240,
  parameter int RAMP_T1    = 480,
  parameter int RAMP_T2    = 960,
  localparam int DATA_W    = CODE_W + 2,
  localparam int ADDR_W    = $clog2(NUM_CH + 2)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tick,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [NUM_CH*CODE_W-1:0]   ledCode,
  output logic                       cpBoost,
  output logic                       shutdown
);

  logic [NUM_CH-1:0][CODE_W-1:0] chCode;
  logic [NUM_CH-1:0][1:0]        chMode;
  logic [CODE_W-1:0]             rampLevel;
  fxStrobe_t                     strobes;

  ledfx_ctrl #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W),
    .ON_SHORT(ON_SHORT), .ON_LONG(ON_LONG),
    .PER_SHORT(PER_SHORT), .PER_LONG(PER_LONG),
    .RAMP_T0(RAMP_T0), .RAMP_T1(RAMP_T1), .RAMP_T2(RAMP_T2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .chCode(chCode), .chMode(chMode),
    .rampLevel(rampLevel), .strobes(strobes)
  );

  ledfx_datapath #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .BOOST_CODE(BOOST_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .chCode(chCode), .chMode(chMode),
    .rampLevel(rampLevel), .strobes(strobes),
    .ledCode(ledCode), .cpBoost(cpBoost)
  );

  assign shutdown = strobes.shutdown;

endmodule

// File: tb/ledfx_seq_tb.sv
module ledfx_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 18;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         tick = 1'b1;
  logic         wrEn = 1'b0;
  logic [4:0]   wrAddr = '0;
  logic [7:0]   wrData = '0;
  logic [107:0] ledCode;
  logic         cpBoost, shutdown;

  int checks = 0;
  int fails = 0;
  int tickMode = 0;      // 0 always, 1 random, 2 never
  bit checkEn = 1'b0;
  bit finished = 1'b0;

  // Cycle model state
  int  mCode [NCH];
  int  mMode [NCH];
  bit  mShutBit, mOnSel, mPerSel, mDir, mAct, mBoost;
  int  mRampSel, mCnt, mLvl, mStp;

  ledfx_seq u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ledCode(ledCode), .cpBoost(cpBoost), .shutdown(shutdown)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int perT();  return mPerSel ? 2500 : 1250; endfunction
  function automatic int onT();   return mOnSel ? 625 : 156; endfunction
  function automatic int stepT();
    return (mRampSel == 0) ? 4 : (mRampSel == 1) ? 8 : 15;
  endfunction

  function automatic bit expShut();
    bit z = 1'b1;
    for (int c = 0; c < NCH; c++) if (mCode[c] != 0) z = 1'b0;
    return !rstN || mShutBit || z;
  endfunction

  function automatic int expOut(int c);
    if (expShut()) return 0;
    case (mMode[c])
      1: return (mCnt < onT()) ? mCode[c] : 0;
      2: return (mLvl < mCode[c]) ? mLvl : mCode[c];
      default: return mCode[c];
    endcase
  endfunction

  function automatic int dutOut(int c);
    return int'((ledCode >> (c * 6)) & 108'd63);
  endfunction

  // Reference model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin mCode[c] = 0; mMode[c] = 0; end
      mShutBit = 0; mOnSel = 0; mPerSel = 0; mDir = 0; mAct = 0; mBoost = 0;
      mRampSel = 0; mCnt = 0; mLvl = 0; mStp = 0;
    end else begin
      automatic bit restart = 1'b0;
      automatic bit nDir = mDir;
      automatic bit hi = 1'b0;
      automatic bit stepNow, dd;
      automatic bit sh = expShut();
      for (int c = 0; c < NCH; c++) if (expOut(c) >= 32) hi = 1'b1;
      if (wrEn && wrAddr == 5'd19 && wrData[4] != mDir) begin restart = 1; nDir = wrData[4]; end
      if (wrEn && wrAddr >= 1 && wrAddr <= 18 && int'(wrData[7:6]) != mMode[wrAddr-1]) restart = 1;
      stepNow = mAct && tick && (mStp >= stepT() - 1) && !restart;
      dd = stepNow && !mDir && mLvl == 1;
      if (sh || dd) mBoost = 0; else if (hi) mBoost = 1;
      if (tick) mCnt = (mCnt >= perT() - 1) ? 0 : mCnt + 1;
      if (restart) begin
        mLvl = nDir ? 0 : 63; mStp = 0; mAct = 1;
      end else if (mAct && tick) begin
        if (stepNow) begin
          mStp = 0;
          if (mDir) begin mLvl++; if (mLvl == 63) mAct = 0; end
          else begin mLvl--; if (mLvl == 0) mAct = 0; end
        end else mStp++;
      end
      if (wrEn) begin
        if (wrAddr == 0) mShutBit = wrData[0];
        else if (wrAddr == 19) begin
          mOnSel = wrData[0]; mPerSel = wrData[1]; mRampSel = int'(wrData[3:2]); mDir = wrData[4];
        end else if (wrAddr <= 18) begin
          mCode[wrAddr-1] = int'(wrData[5:0]); mMode[wrAddr-1] = int'(wrData[7:6]);
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (checkEn && rstN && !finished) begin
      check("R9 shutdown", int'(shutdown), int'(expShut()));
      check("R10 cpBoost", int'(cpBoost), int'(mBoost));
      for (int c = 0; c < NCH; c++) begin
        case (mMode[c])
          0: check("R2 static", dutOut(c), expOut(c));
          1: check("R3 flash", dutOut(c), expOut(c));
          2: check(mDir ? "R5 ramp up" : "R6 ramp down", dutOut(c), expOut(c));
          default: check("R12 alt mode", dutOut(c), expOut(c));
        endcase
      end
    end
  end

  // Tick driver
  initial begin
    forever begin
      @(negedge clk);
      case (tickMode)
        0: tick = 1'b1;
        1: tick = ($urandom % 2) == 0;
        default: tick = 1'b0;
      endcase
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int cnt;
    int prev;
    void'($urandom(32'h5eed1234));
    // R1: reset state, writes ignored while held
    idle(3);
    check("R1 shutdown in reset", int'(shutdown), 1);
    check("R1 codes in reset", int'(ledCode == '0), 1);
    check("R1 boost in reset", int'(cpBoost), 0);
    wr(1, 8'h28);
    @(negedge clk); rstN = 1'b1;
    idle(2);
    check("R1 write blocked", dutOut(0), 0);
    check("R1 shutdown after release", int'(shutdown), 1);
    checkEn = 1'b1;

    // R2 static, R10 boost set
    wr(1, 40);
    check("R2 static code", dutOut(0), 40);
    idle(1);
    check("R10 boost set", int'(cpBoost), 1);
    // R12 alt mode, unused address
    wr(2, 8'hC5);
    check("R12 mode 11 static", dutOut(1), 5);
    wr(25, 8'hFF);
    idle(1);
    check("R12 unused address", dutOut(0), 40);

    // R7 up-ramp step of 4 ticks
    wr(19, 8'h10);
    wr(3, 8'hBF);
    idle(40);
    check("R7 level after 40 ticks", dutOut(2), 10);
    // R4 flash settings change mid-ramp
    wr(19, 8'h13);
    idle(38);
    check("R4 ramp undisturbed", dutOut(2), 20);
    // R11 no tick, no motion
    tickMode = 2;
    idle(50);
    check("R11 frozen ramp", dutOut(2), 20);
    tickMode = 0;
    // R8 hold at end
    wr(1, 0);
    idle(300);
    check("R8 held at top", dutOut(2), 63);

    // R6 down-ramp, R10 hysteresis and release
    wr(19, 8'h00);
    idle(200);
    check("R10 boost held during ramp", int'(cpBoost), 1);
    idle(60);
    check("R6 ramp reached zero", dutOut(2), 0);
    check("R10 boost released", int'(cpBoost), 0);

    // R9 all codes zero, then command bit
    wr(2, 0); wr(3, 8'h80);
    idle(2);
    check("R9 all zero shutdown", int'(shutdown), 1);
    wr(1, 30);
    check("R9 awake", int'(shutdown), 0);
    wr(0, 1);
    check("R9 command shutdown", int'(shutdown), 1);
    check("R9 dark", dutOut(0), 0);
    wr(0, 0);

    // R3 flash duty over one period, short and long settings
    wr(19, 8'h00);
    wr(4, 8'h72);
    idle(1300);
    cnt = 0;
    for (int i = 0; i < 1250; i++) begin @(negedge clk); if (dutOut(3) != 0) cnt++; end
    check("R3 short on-ticks", cnt, 156);
    wr(19, 8'h03);
    idle(2600);
    cnt = 0;
    for (int i = 0; i < 2500; i++) begin @(negedge clk); if (dutOut(3) != 0) cnt++; end
    check("R3 long on-ticks", cnt, 625);

    // Constrained random phase
    for (int it = 0; it < 200; it++) begin
      int r = $urandom % 100;
      tickMode = ($urandom % 4 == 0) ? 1 : 0;
      if (r < 65)      wr(1 + $urandom % 18, $urandom % 256);
      else if (r < 85) wr(19, $urandom % 32);
      else if (r < 90) wr(0, ($urandom % 4 == 0) ? 1 : 0);
      else if (r < 95) wr(20 + $urandom % 12, $urandom % 256);
      else             wr(0, 0);
      prev = $urandom % 300;
      idle(1 + prev);
    end
    tickMode = 0;
    idle(5);
    summary();
  end

endmodule